// File: doc/BRIEF.md
# Pipelined Five-Input NAND Network

The block evaluates a fixed three-level network of two-input NAND gates that maps five data bits to two result bits. Its depth parameter `STAGES` selects 0, 1, 2 or 3 pipeline stages.

At depth 0 the network is purely combinational. At depth 1 a register rank sits on every primary input and every primary output. Depths 2 and 3 add internal register ranks between gate levels. Any signal that skips a gate level is carried through extra balancing flip-flops, so the two results always belong to the same input vector. A new vector may be applied on every clock cycle.

All storage is built from a separate rising-edge D flip-flop module. That flip-flop has active-high asynchronous set and clear. The block reset is active low and asynchronous. It is released to the pipeline through a two-flop synchronizer, and while it is asserted every pipeline register holds zero.

Network, with `din[0]` as the first input through `din[4]` as the fifth:
- n1 = NAND(din[0], din[2])
- n2 = NAND(din[2], din[3])
- n3 = NAND(din[1], n2)
- n4 = NAND(n2, din[4])
- dout[0] = NAND(n1, n3)
- dout[1] = NAND(n3, n4)

Top module: `nand_net_pipe`

## Requirements
- R1: With STAGES=0, dout equals the network function of din in the same cycle, for all 32 input values.
- R2: With STAGES=1, dout equals the network function of the din value sampled 2 rising edges earlier, for every vector of a back-to-back stream covering all 32 values.
- R3: With STAGES=2, dout equals the network function of the din value sampled 3 rising edges earlier, for every vector of a back-to-back stream, with both bits from the same vector.
- R4: With STAGES=3, dout equals the network function of the din value sampled 4 rising edges earlier, for every vector of a back-to-back stream, with both bits from the same vector.
- R5: For STAGES of 1 or more, when rst_n goes low every pipeline register clears at once without waiting for a clock edge, and dout reads 2'b00 for as long as rst_n stays low.
- R6: After rst_n rises between clock edges, dout stays 2'b00 through the second following rising edge. From rising edge 2+L onward dout carries valid results, where L is the latency (STAGES+1).
- R7: In the flip-flop module, a high clear forces q to 0 and a high set forces q to 1, both without a clock edge. When both are high, clear wins.
- R8: In the flip-flop module, with set and clear low, q takes d at each rising clock edge and holds it between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers capture on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| din | input | 5 | Network inputs, bit k is input k+1 |
| dout | output | 2 | Network results, bit 0 first output, bit 1 second output |

## Verification
A missing or extra balancing flip-flop on one path pairs values from two different input vectors. This shows up as a wrong result bit once a stream of changing vectors is applied, and appears L edges after the vector enters. A constant input would hide it, so every depth is driven with a scrambled back-to-back order of all 32 values. A register that fails to clear shows as a nonzero output during reset or within the first two edges after release. A broken synchronizer moves the first valid output away from edge 2+L.

// File: rtl/nand_net_pkg.sv
package nand_net_pkg;

  localparam int unsigned NET_IN  = 5;
  localparam int unsigned NET_OUT = 2;
  localparam int unsigned LVL1_W  = 4;  // n1, n2 plus din[1], din[4] carried forward
  localparam int unsigned LVL2_W  = 3;  // n1 carried forward plus n3, n4

  // Golden evaluation of the network, used by the latency assertions.
  function automatic logic [NET_OUT-1:0] net_eval(input logic [NET_IN-1:0] v);
    logic a, b, c, d;
    a = ~(v[0] & v[2]);
    b = ~(v[2] & v[3]);
    c = ~(v[1] & b);
    d = ~(b & v[4]);
    return {~(c & d), ~(a & c)};
  endfunction

endpackage

// File: rtl/edge_flop.sv
module edge_flop (
  input  logic clk,
  input  logic set_i,
  input  logic clr_i,
  input  logic d_i,
  output logic q_o
);

  always_ff @(posedge clk or posedge clr_i or posedge set_i) begin
    if (clr_i)      q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else            q_o <= d_i;
  end

  // R7: clear dominates, set forces one
  a_r7_clear_wins: assert property (@(posedge clk) clr_i |-> !q_o);
  a_r7_set_forces: assert property (@(posedge clk) (set_i && !clr_i) |-> q_o);
  // R8: plain capture at the rising edge
  a_r8_capture: assert property (@(posedge clk)
    (!clr_i && !set_i) |=> (clr_i || set_i || (q_o == $past(d_i))));

endmodule

// File: rtl/reset_sync.sv
module reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic clr;
  logic stage1;

  assign clr = ~rst_n;

  edge_flop u_s1 (.clk(clk), .set_i(1'b0), .clr_i(clr), .d_i(1'b1),   .q_o(stage1));
  edge_flop u_s2 (.clk(clk), .set_i(1'b0), .clr_i(clr), .d_i(stage1), .q_o(rst_sync_n));

  // R6: asserted immediately, released only after two edges with rst_n high
  a_r6_hold_low: assert property (@(posedge clk) !rst_n |-> !rst_sync_n);
  a_r6_late_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_sync_n) |-> $past(rst_n, 2));

endmodule

// File: rtl/cut_reg.sv
module cut_reg #(
  parameter int unsigned W  = 1,
  parameter bit          EN = 1'b1
) (
  input  logic         clk,
  input  logic         clr_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  if (EN) begin : g_reg
    for (genvar i = 0; i < W; i++) begin : g_bit
      edge_flop u_bit (
        .clk  (clk),
        .set_i(1'b0),
        .clr_i(clr_i),
        .d_i  (d_i[i]),
        .q_o  (q_o[i])
      );
    end
    // R5: a cleared rank reads zero
    a_r5_rank_clear: assert property (@(posedge clk) clr_i |-> (q_o == '0));
  end else begin : g_wire
    assign q_o = d_i;
  end

endmodule

// File: rtl/nand2.sv
module nand2 (
  input  logic a_i,
  input  logic b_i,
  output logic y_o
);

  assign y_o = ~(a_i & b_i);

endmodule

// File: rtl/nand_net_pipe.sv
module nand_net_pipe
  import nand_net_pkg::*;
#(
  parameter int unsigned STAGES = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NET_IN-1:0]  din,
  output logic [NET_OUT-1:0] dout
);

  localparam bit          EDGE_REGS = (STAGES >= 1);
  localparam bit          CUT_L1    = (STAGES == 3);  // after first gate level
  localparam bit          CUT_L2    = (STAGES >= 2);  // after second gate level
  localparam int unsigned LAT       = EDGE_REGS ? STAGES + 1 : 0;

  logic rst_sync_n;
  logic clr;

  reset_sync u_rsync (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));
  assign clr = ~rst_sync_n;

  // input rank
  logic [NET_IN-1:0] x;
  cut_reg #(.W(NET_IN), .EN(EDGE_REGS)) u_cut_in (
    .clk(clk), .clr_i(clr), .d_i(din), .q_o(x));

  // level 1
  logic n1, n2;
  nand2 u_n1 (.a_i(x[0]), .b_i(x[2]), .y_o(n1));
  nand2 u_n2 (.a_i(x[2]), .b_i(x[3]), .y_o(n2));

  // cut after level 1: din[1] and din[4] ride along with the gate outputs
  logic [LVL1_W-1:0] l1_d, l1_q;
  assign l1_d = {x[4], x[1], n2, n1};
  cut_reg #(.W(LVL1_W), .EN(CUT_L1)) u_cut_l1 (
    .clk(clk), .clr_i(clr), .d_i(l1_d), .q_o(l1_q));

  // level 2
  logic n3, n4;
  nand2 u_n3 (.a_i(l1_q[2]), .b_i(l1_q[1]), .y_o(n3));
  nand2 u_n4 (.a_i(l1_q[1]), .b_i(l1_q[3]), .y_o(n4));

  // cut after level 2: n1 skips level 2 and is balanced here
  logic [LVL2_W-1:0] l2_d, l2_q;
  assign l2_d = {n4, n3, l1_q[0]};
  cut_reg #(.W(LVL2_W), .EN(CUT_L2)) u_cut_l2 (
    .clk(clk), .clr_i(clr), .d_i(l2_d), .q_o(l2_q));

  // level 3
  logic [NET_OUT-1:0] y;
  nand2 u_y0 (.a_i(l2_q[0]), .b_i(l2_q[1]), .y_o(y[0]));
  nand2 u_y1 (.a_i(l2_q[1]), .b_i(l2_q[2]), .y_o(y[1]));

  // output rank
  cut_reg #(.W(NET_OUT), .EN(EDGE_REGS)) u_cut_out (
    .clk(clk), .clr_i(clr), .d_i(y), .q_o(dout));

  // Fill counter for checking only: edges since synchronized release, saturating at LAT
  logic [2:0] fill_q, fill_d;
  always_comb begin
    fill_d = (fill_q == 3'(LAT)) ? fill_q : fill_q + 3'd1;
  end
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) fill_q <= '0;
    else             fill_q <= fill_d;
  end

  if (LAT > 0) begin : g_chk_seq
    // R2, R3, R4: both results match the vector taken LAT edges earlier
    a_r4_aligned_latency: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_q == 3'(LAT)) |-> (dout == net_eval($past(din, LAT))));
    // R5: outputs read zero while reset is held
    a_r5_out_zero: assert property (@(posedge clk) !rst_n |-> (dout == '0));
  end else begin : g_chk_comb
    // R1: combinational variant follows din directly
    a_r1_comb_eval: assert property (@(posedge clk) disable iff (!rst_n)
      dout == net_eval(din));
  end

endmodule

// File: tb/sim_nand_net_pipe.sv
module sim_nand_net_pipe;

  logic       clk;
  logic       rst_n;
  logic [4:0] din;
  logic [1:0] y0, y1, y2, y3;   // outputs of the depth 0, 1, 2, 3 variants
  logic       f_set, f_clr, f_d, f_q;
  int         n_chk;
  int         n_bad;
  bit         done;

  nand_net_pipe #(.STAGES(3)) u0 (.clk(clk), .rst_n(rst_n), .din(din), .dout(y3));
  nand_net_pipe #(.STAGES(0)) u1 (.clk(clk), .rst_n(rst_n), .din(din), .dout(y0));
  nand_net_pipe #(.STAGES(1)) u2 (.clk(clk), .rst_n(rst_n), .din(din), .dout(y1));
  nand_net_pipe #(.STAGES(2)) u3 (.clk(clk), .rst_n(rst_n), .din(din), .dout(y2));
  edge_flop ud (.clk(clk), .set_i(f_set), .clr_i(f_clr), .d_i(f_d), .q_o(f_q));

  // 100 MHz, 20% duty cycle: 2 ns high, 8 ns low
  initial begin
    clk = 1'b0;
    forever begin
      #8 clk = 1'b1;
      #2 clk = 1'b0;
    end
  end

  // Sum-of-products form of the network
  function automatic logic [1:0] golden(input logic [4:0] v);
    logic a, b, c, d, e;
    {e, d, c, b, a} = v;
    golden[0] = (a & c) | (b & ~(c & d));
    golden[1] = ~(c & d) & (b | e);
  endfunction

  function automatic logic [4:0] vec(input int k);
    return 5'((k * 13 + 7) % 32);
  endfunction

  task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #4;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    f_set = 1'b0; f_clr = 1'b0; f_d = 1'b0;
    rst_n = 1'b1;
    din = 5'b00111;   // both results are 1 for this vector
    #1 rst_n = 1'b0;
    repeat (3) tick();

    // R5: all registered variants read zero under reset
    chk("R5 reset depth1", y1, 2'b00);
    chk("R5 reset depth2", y2, 2'b00);
    chk("R5 reset depth3", y3, 2'b00);
    chk("R1 comb during reset", y0, golden(din));

    // R6: release between edges, then count edges
    rst_n = 1'b1;
    for (int e = 1; e <= 6; e++) begin
      tick();
      if (e <= 2) begin
        chk("R6 quiet depth1", y1, 2'b00);
        chk("R6 quiet depth2", y2, 2'b00);
        chk("R6 quiet depth3", y3, 2'b00);
      end
      if (e >= 4) chk("R6 first valid depth1", y1, 2'b11);
      if (e >= 5) chk("R6 first valid depth2", y2, 2'b11);
      if (e >= 6) chk("R6 first valid depth3", y3, 2'b11);
    end

    // Stream all 32 vectors back to back; vec(k) driven in slot k
    for (int n = 0; n < 37; n++) begin
      if (n > 0) tick();
      if (n >= 2 && n - 2 < 32) chk("R2 depth1 stream", y1, golden(vec(n - 2)));
      if (n >= 3 && n - 3 < 32) chk("R3 depth2 stream", y2, golden(vec(n - 3)));
      if (n >= 4 && n - 4 < 32) chk("R4 depth3 stream", y3, golden(vec(n - 4)));
      if (n < 32) begin
        din = vec(n);
        #1;
        chk("R1 comb sweep", y0, golden(din));
      end
    end

    // R5: asynchronous clear in mid cycle
    tick();
    rst_n = 1'b0;
    #1;
    chk("R5 async clear depth1", y1, 2'b00);
    chk("R5 async clear depth2", y2, 2'b00);
    chk("R5 async clear depth3", y3, 2'b00);
    tick();
    chk("R5 held clear depth3", y3, 2'b00);
    rst_n = 1'b1;

    // R7: flip-flop asynchronous controls
    f_d = 1'b1; f_clr = 1'b1;
    #1 chk("R7 clear without edge", {1'b0, f_q}, 2'b00);
    tick();
    f_d = 1'b0; f_clr = 1'b0; f_set = 1'b1;
    #1 chk("R7 set without edge", {1'b0, f_q}, 2'b01);
    tick();
    chk("R7 set held over edge", {1'b0, f_q}, 2'b01);
    f_clr = 1'b1;
    #1 chk("R7 clear wins over set", {1'b0, f_q}, 2'b00);
    tick();
    chk("R7 clear wins after edge", {1'b0, f_q}, 2'b00);

    // R8: plain capture and hold
    f_clr = 1'b0; f_set = 1'b0; f_d = 1'b1;
    #1 chk("R8 hold before edge", {1'b0, f_q}, 2'b00);
    tick();
    chk("R8 capture one", {1'b0, f_q}, 2'b01);
    f_d = 1'b0;
    #1 chk("R8 hold one", {1'b0, f_q}, 2'b01);
    tick();
    chk("R8 capture zero", {1'b0, f_q}, 2'b00);

    finish_run();
  end

endmodule